// File: doc/BRIEF.md
# Flash Programmer Host Sequencer

This block is the host side of a byte-wide flash programming port. On a `start` pulse it can first read the manufacturer signature byte and stop if the code is wrong. It then erases the whole array and accepts an image as a stream of address/data entries under a valid/ready handshake. For each entry it drives the address and data, selects the write control combination and raises the high-voltage enable. It then gives one strobe pulse and waits for the device to finish the write. Last, it reads the byte back and compares it with the image.

Completion is detected in one of two ways, chosen by the `COMP_POLL` parameter. The ready/busy method watches the busy line go low and then high again. The data-polling method keeps reading the written address until the most significant data bit reads back true. A timeout bounds every wait. A wrong signature, a read-back mismatch or a timeout stops the run with a sticky error flag. A one-cycle done pulse marks an image whose final entry verified.

States: `ST_IDLE`, `ST_SIG` (signature read), `ST_ERASE`, `ST_FETCH` (waiting for an image entry), `ST_SETUP`, `ST_PULSE`, `ST_WAIT` (completion), `ST_VERIFY`, `ST_DONE`, `ST_FAIL`. The transitions are:
- idle or fail goes to sig (or to erase if `CHECK_SIG`=0) on start;
- sig goes to erase on a matching code and to fail otherwise;
- erase goes to fetch after `ERASE_CYC` cycles;
- fetch goes to setup on a handshake;
- setup goes to pulse after `SETUP_CYC` cycles;
- pulse goes to wait after `PULSE_CYC` cycles;
- wait goes to verify on completion and to fail on timeout;
- verify goes to fetch, to done (last entry) or to fail on a mismatch;
- done goes to idle after one cycle.

Top module: `flash_prog_seq`

## Requirements
- R1: Out of reset and while idle: `pg_strobe_n`=1, `pg_hv`=0, `pg_sel_n`=2'b11, `pg_mode`=0 (idle), and `img_ready`, `done` and `error` are all 0.
- R2: With `CHECK_SIG`=1, a run starts by reading address 0x30 in read mode (`pg_mode`=1) with `pg_sel_n`=2'b00. A value other than 0x1E sets `error`, and then no erase is issued and no image entry is accepted.
- R3: Before the first image entry of a run is accepted, one erase is issued. During the erase, `pg_mode`=3, `pg_hv`=1 and `pg_strobe_n` is low for exactly `ERASE_CYC` cycles. No write strobe occurs in a run before its erase.
- R4: An entry is captured on a cycle with `img_valid` and `img_ready` both high. The sequencer then drives that address and data in write mode (`pg_mode`=2) with `pg_hv`=1 and the strobe high for `SETUP_CYC` cycles. After that it drives `pg_strobe_n` low once, for exactly `PULSE_CYC` cycles. The strobe is never low with `pg_hv`=0.
- R5: With `COMP_POLL`=0, the write is complete only after `pg_busy_n` has been seen low and then high. The sequencer does not read the array while it waits.
- R6: With `COMP_POLL`=1, the sequencer reads the written address in read mode until `pg_rdata` bit `DATA_W-1` equals the same bit of the written data. The wait starts right after the strobe.
- R7: After completion the written address is read back. If the read-back byte differs from the image byte, `error` is set and no further entry is accepted.
- R8: If completion is not seen within `TIMEOUT_CYC` cycles of the start of the wait, `error` is set.
- R9: When the entry marked `img_last` verifies, `done` is high for exactly one cycle and the block returns to idle. `done` and `error` are never high together.
- R10: `error` stays high until the next `start`, which clears it and begins a new run.
- R11: While `img_ready` is high, `pg_strobe_n`=1 and `pg_hv`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in idle or after an error) |
| img_valid | input | 1 | Image entry valid |
| img_ready | output | 1 | Sequencer can accept an entry |
| img_addr | input | ADDR_W | Entry address |
| img_data | input | DATA_W | Entry data |
| img_last | input | 1 | Final entry of the image |
| pg_addr | output | ADDR_W | Address to the flash port |
| pg_wdata | output | DATA_W | Write data to the flash port |
| pg_rdata | input | DATA_W | Read data from the flash port |
| pg_mode | output | 3 | Control combination: 0 idle, 1 read, 2 write, 3 erase |
| pg_hv | output | 1 | High-voltage enable request |
| pg_strobe_n | output | 1 | Active-low program strobe |
| pg_sel_n | output | 2 | Signature-select lines, low during the signature read |
| pg_busy_n | input | 1 | Device ready (1) / busy (0) |
| done | output | 1 | One-cycle pulse: image written and verified |
| error | output | 1 | Sticky failure flag |

## Verification
Two functions meet in the completion wait: the write-completion detector and the timeout counter. Either can end the `ST_WAIT` state, and a slow device makes them race. The bench sets the device model's write time well beyond `TIMEOUT_CYC`. It then checks that `error` rises no earlier than the timeout and that `done` never appears. The handshake and read-back verify also meet, because a corrupting device model makes the verify fail. Meanwhile the next entry is held valid, and the bench confirms that it is never taken.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SIG,
        ST_ERASE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_VERIFY,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam logic [2:0] MODE_IDLE = 3'd0;
    localparam logic [2:0] MODE_RD   = 3'd1;
    localparam logic [2:0] MODE_WR   = 3'd2;
    localparam logic [2:0] MODE_ER   = 3'd3;

    localparam logic [7:0] MFR_CODE  = 8'h1E;
    localparam logic [7:0] SIG_LOC   = 8'h30;

endpackage

// File: rtl/flash_seq_cnt.sv
module flash_seq_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/flash_seq_cmpl.sv
module flash_seq_cmpl #(
    parameter bit POLL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sense,
    output logic complete
);

    generate
        if (POLL) begin : g_poll
            // sense = polled bit matches; one registered sample filters the first read
            logic hit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hit_q <= 1'b0;
                else        hit_q <= arm & sense;
            end
            assign complete = arm & hit_q;
        end else begin : g_rdybsy
            // sense = busy_n; need a low phase before a high one
            logic seen_low_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) seen_low_q <= 1'b0;
                else        seen_low_q <= arm & (seen_low_q | ~sense);
            end
            assign complete = arm & seen_low_q & sense;
        end
    endgenerate

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int ERASE_CYC   = 16,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 2,
    parameter int RD_CYC      = 2,
    parameter int TIMEOUT_CYC = 40,
    parameter bit COMP_POLL   = 1'b0,
    parameter bit CHECK_SIG   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              img_valid,
    output logic              img_ready,
    input  logic [ADDR_W-1:0] img_addr,
    input  logic [DATA_W-1:0] img_data,
    input  logic              img_last,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [DATA_W-1:0] pg_wdata,
    input  logic [DATA_W-1:0] pg_rdata,
    output logic [2:0]        pg_mode,
    output logic              pg_hv,
    output logic              pg_strobe_n,
    output logic [1:0]        pg_sel_n,
    input  logic              pg_busy_n,
    output logic              done,
    output logic              error
);

    localparam int MAX_A   = (ERASE_CYC > TIMEOUT_CYC) ? ERASE_CYC : TIMEOUT_CYC;
    localparam int MAX_B   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C   = (MAX_B > RD_CYC) ? MAX_B : RD_CYC;
    localparam int CNT_MAX = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;
    localparam int MSB     = DATA_W - 1;

    localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PU_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_t        state_q, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr;
    logic              sense;
    logic              complete;
    logic              take;

    assign take    = img_valid & img_ready;
    assign cnt_clr = (state_nx != state_q);
    assign sense   = COMP_POLL ? (pg_rdata[MSB] == data_q[MSB]) : pg_busy_n;

    flash_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .count (cnt)
    );

    flash_seq_cmpl #(.POLL(COMP_POLL)) u_cmpl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (state_q == ST_WAIT),
        .sense    (sense),
        .complete (complete)
    );

    // State register and captured image entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (take) begin
                addr_q <= img_addr;
                data_q <= img_data;
                last_q <= img_last;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAIL: begin
                if (start) state_nx = CHECK_SIG ? ST_SIG : ST_ERASE;
            end
            ST_SIG: begin
                if (cnt == RD_LAST)
                    state_nx = (pg_rdata == DATA_W'(MFR_CODE)) ? ST_ERASE : ST_FAIL;
            end
            ST_ERASE: begin
                if (cnt == ER_LAST) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (take) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                if (cnt == SU_LAST) state_nx = ST_PULSE;
            end
            ST_PULSE: begin
                if (cnt == PU_LAST) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (complete)           state_nx = ST_VERIFY;
                else if (cnt == TO_LAST) state_nx = ST_FAIL;
            end
            ST_VERIFY: begin
                if (cnt == RD_LAST) begin
                    if (pg_rdata != data_q) state_nx = ST_FAIL;
                    else if (last_q)        state_nx = ST_DONE;
                    else                    state_nx = ST_FETCH;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pg_addr     = addr_q;
        pg_wdata    = data_q;
        pg_mode     = MODE_IDLE;
        pg_hv       = 1'b0;
        pg_strobe_n = 1'b1;
        pg_sel_n    = 2'b11;
        img_ready   = 1'b0;
        done        = 1'b0;
        error       = 1'b0;
        unique case (state_q)
            ST_SIG: begin
                pg_addr  = ADDR_W'(SIG_LOC);
                pg_mode  = MODE_RD;
                pg_sel_n = 2'b00;
            end
            ST_ERASE: begin
                pg_mode     = MODE_ER;
                pg_hv       = 1'b1;
                pg_strobe_n = 1'b0;
            end
            ST_FETCH:  img_ready = 1'b1;
            ST_SETUP: begin
                pg_mode = MODE_WR;
                pg_hv   = 1'b1;
            end
            ST_PULSE: begin
                pg_mode     = MODE_WR;
                pg_hv       = 1'b1;
                pg_strobe_n = 1'b0;
            end
            ST_WAIT:   pg_mode = COMP_POLL ? MODE_RD : MODE_IDLE;
            ST_VERIFY: pg_mode = MODE_RD;
            ST_DONE:   done  = 1'b1;
            ST_FAIL:   error = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ERASE_CYC = 16,
    parameter int PULSE_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              img_ready,
    input logic [ADDR_W-1:0] pg_addr,
    input logic [2:0]        pg_mode,
    input logic              pg_hv,
    input logic              pg_strobe_n,
    input logic [1:0]        pg_sel_n,
    input logic              done,
    input logic              error
);

    logic [15:0] lo_len;
    logic [2:0]  lo_mode;
    logic        erased_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_len      <= '0;
            lo_mode     <= MODE_IDLE;
            erased_seen <= 1'b0;
        end else begin
            lo_len <= pg_strobe_n ? 16'd0 : lo_len + 16'd1;
            if (!pg_strobe_n) lo_mode <= pg_mode;
            if (done || error)
                erased_seen <= 1'b0;
            else if (pg_strobe_n && lo_len != 16'd0 && lo_mode == MODE_ER)
                erased_seen <= 1'b1;
        end
    end

    p_strobe_needs_hv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_strobe_n |-> pg_hv);

    p_erase_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pg_strobe_n) && lo_mode == MODE_ER) |-> (lo_len == 16'(ERASE_CYC)));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pg_strobe_n) && lo_mode == MODE_WR) |-> (lo_len == 16'(PULSE_CYC)));

    p_erase_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pg_strobe_n) && pg_mode == MODE_WR) |-> erased_seen);

    p_sig_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_sel_n != 2'b11) |-> (pg_mode == MODE_RD && pg_addr == ADDR_W'(SIG_LOC) && !pg_hv));

    p_fetch_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> (pg_strobe_n && !pg_hv));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .ERASE_CYC (ERASE_CYC),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .img_ready   (img_ready),
    .pg_addr     (pg_addr),
    .pg_mode     (pg_mode),
    .pg_hv       (pg_hv),
    .pg_strobe_n (pg_strobe_n),
    .pg_sel_n    (pg_sel_n),
    .done        (done),
    .error       (error)
);

// File: tb/flash_prog_seq_tb_top.sv
`timescale 1ns/1ps

module flash_dev_model (
    input  logic       clk,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic [2:0] mode,
    input  logic       hv,
    input  logic       strobe_n,
    input  logic [1:0] sel_n,
    output logic [7:0] rdata,
    output logic       busy_n,
    input  int         wr_time,
    input  logic [7:0] mfr,
    input  logic       corrupt,
    input  logic [7:0] peek_addr,
    output logic [7:0] peek_data,
    output int         erase_cnt,
    output int         write_cnt,
    output int         er_len,
    output int         pulse_len,
    output int         setup_len,
    output int         bad_cnt,
    output int         poll_reads
);
    logic [7:0] mem [256];
    logic       prev_sn;
    logic [2:0] lo_mode;
    int         lo_len, su, busy_cnt;
    logic [7:0] last_addr, pend;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        prev_sn = 1'b1; lo_mode = 3'd0; lo_len = 0; su = 0; busy_cnt = 0;
        last_addr = 8'h00; pend = 8'h00;
        erase_cnt = 0; write_cnt = 0; er_len = 0; pulse_len = 0;
        setup_len = 0; bad_cnt = 0; poll_reads = 0;
    end

    assign busy_n    = (busy_cnt == 0);
    assign peek_data = mem[peek_addr];

    always @* begin
        if (mode == 3'd1 && sel_n == 2'b00 && addr == 8'h30)
            rdata = mfr;
        else if (busy_cnt > 0 && addr == last_addr)
            rdata = {~pend[7], mem[addr][6:0]};
        else
            rdata = mem[addr];
    end

    always @(posedge clk) begin
        if (busy_cnt > 0) begin
            if (mode == 3'd1 && addr == last_addr && sel_n == 2'b11)
                poll_reads = poll_reads + 1;
            busy_cnt = busy_cnt - 1;
            if (busy_cnt == 0) begin
                mem[last_addr] = pend;
                write_cnt = write_cnt + 1;
            end
        end
        if (strobe_n && hv && mode == 3'd2) su = su + 1;
        else if (strobe_n) su = 0;
        if (prev_sn && !strobe_n) begin
            lo_mode = mode;
            lo_len  = 1;
            if (!hv) bad_cnt = bad_cnt + 1;
            if (mode == 3'd2) begin
                if (erase_cnt == 0) bad_cnt = bad_cnt + 1;
                setup_len = su;
                last_addr = addr;
                pend      = wdata ^ {7'd0, corrupt};
                busy_cnt  = wr_time;
            end
        end else if (!strobe_n) begin
            lo_len = lo_len + 1;
        end
        if (!prev_sn && strobe_n) begin
            if (lo_mode == 3'd3) begin
                er_len = lo_len;
                erase_cnt = erase_cnt + 1;
                for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
            end else if (lo_mode == 3'd2) begin
                pulse_len = lo_len;
            end
        end
        prev_sn = strobe_n;
    end
endmodule

module flash_prog_seq_tb_top;
    localparam int ERASE_CYC   = 16;
    localparam int SETUP_CYC   = 2;
    localparam int PULSE_CYC   = 2;
    localparam int TIMEOUT_CYC = 40;
    localparam int NV          = 6;

    // {last, addr, expected data}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h3C},
        {1'b0, 8'h01, 8'hA5},
        {1'b0, 8'h7F, 8'h80},
        {1'b0, 8'h80, 8'h7E},
        {1'b0, 8'hFE, 8'h00},
        {1'b1, 8'hFF, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       start_s   [2];
    logic       valid_s   [2];
    logic       ready_s   [2];
    logic [7:0] iaddr_s   [2];
    logic [7:0] idata_s   [2];
    logic       ilast_s   [2];
    logic [7:0] paddr_s   [2];
    logic [7:0] pwd_s     [2];
    logic [7:0] prd_s     [2];
    logic [2:0] pmode_s   [2];
    logic       phv_s     [2];
    logic       pstb_s    [2];
    logic [1:0] psel_s    [2];
    logic       pbusy_s   [2];
    logic       done_s    [2];
    logic       err_s     [2];
    int         wrt_s     [2];
    logic [7:0] mfr_s     [2];
    logic       corr_s    [2];
    logic [7:0] peek_a    [2];
    logic [7:0] peek_d    [2];
    int erase_c [2]; int write_c [2]; int er_l [2]; int pu_l [2];
    int su_l [2]; int bad_c [2]; int poll_c [2];

    flash_prog_seq #(.ADDR_W(8), .ERASE_CYC(ERASE_CYC), .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .COMP_POLL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start_s[0]), .img_valid(valid_s[0]),
        .img_ready(ready_s[0]), .img_addr(iaddr_s[0]), .img_data(idata_s[0]),
        .img_last(ilast_s[0]), .pg_addr(paddr_s[0]), .pg_wdata(pwd_s[0]),
        .pg_rdata(prd_s[0]), .pg_mode(pmode_s[0]), .pg_hv(phv_s[0]),
        .pg_strobe_n(pstb_s[0]), .pg_sel_n(psel_s[0]), .pg_busy_n(pbusy_s[0]),
        .done(done_s[0]), .error(err_s[0]));

    flash_prog_seq #(.ADDR_W(8), .ERASE_CYC(ERASE_CYC), .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .COMP_POLL(1'b1)) dut_p (
        .clk(clk), .rst_n(rst_n), .start(start_s[1]), .img_valid(valid_s[1]),
        .img_ready(ready_s[1]), .img_addr(iaddr_s[1]), .img_data(idata_s[1]),
        .img_last(ilast_s[1]), .pg_addr(paddr_s[1]), .pg_wdata(pwd_s[1]),
        .pg_rdata(prd_s[1]), .pg_mode(pmode_s[1]), .pg_hv(phv_s[1]),
        .pg_strobe_n(pstb_s[1]), .pg_sel_n(psel_s[1]), .pg_busy_n(pbusy_s[1]),
        .done(done_s[1]), .error(err_s[1]));

    flash_dev_model dev0 (.clk(clk), .addr(paddr_s[0]), .wdata(pwd_s[0]), .mode(pmode_s[0]),
        .hv(phv_s[0]), .strobe_n(pstb_s[0]), .sel_n(psel_s[0]), .rdata(prd_s[0]),
        .busy_n(pbusy_s[0]), .wr_time(wrt_s[0]), .mfr(mfr_s[0]), .corrupt(corr_s[0]),
        .peek_addr(peek_a[0]), .peek_data(peek_d[0]), .erase_cnt(erase_c[0]),
        .write_cnt(write_c[0]), .er_len(er_l[0]), .pulse_len(pu_l[0]),
        .setup_len(su_l[0]), .bad_cnt(bad_c[0]), .poll_reads(poll_c[0]));

    flash_dev_model dev1 (.clk(clk), .addr(paddr_s[1]), .wdata(pwd_s[1]), .mode(pmode_s[1]),
        .hv(phv_s[1]), .strobe_n(pstb_s[1]), .sel_n(psel_s[1]), .rdata(prd_s[1]),
        .busy_n(pbusy_s[1]), .wr_time(wrt_s[1]), .mfr(mfr_s[1]), .corrupt(corr_s[1]),
        .peek_addr(peek_a[1]), .peek_data(peek_d[1]), .erase_cnt(erase_c[1]),
        .write_cnt(write_c[1]), .er_len(er_l[1]), .pulse_len(pu_l[1]),
        .setup_len(su_l[1]), .bad_cnt(bad_c[1]), .poll_reads(poll_c[1]));

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int k);
        @(negedge clk); start_s[k] = 1'b1;
        @(negedge clk); start_s[k] = 1'b0;
    endtask

    task automatic feed(input int k, input int i, input bit keep, output bit acc);
        acc = 1'b0;
        @(negedge clk);
        valid_s[k] = 1'b1;
        iaddr_s[k] = VEC[i][15:8];
        idata_s[k] = VEC[i][7:0];
        ilast_s[k] = VEC[i][16];
        for (int c = 0; c < 300; c++) begin
            if (ready_s[k]) begin
                @(posedge clk);
                acc = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (acc) @(negedge clk);
        if (!keep) valid_s[k] = 1'b0;
    endtask

    task automatic wait_end(input int k, input int maxc, output bit d, output bit e,
                            output bit saw_rdy, output int cyc);
        d = 0; e = 0; saw_rdy = 0; cyc = 0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            cyc = c + 1;
            if (ready_s[k]) saw_rdy = 1;
            if (done_s[k]) begin d = 1; break; end
            if (err_s[k])  begin e = 1; break; end
        end
    endtask

    task automatic run_full(input int k, input string req);
        bit acc, d, e, r;
        int cyc;
        pulse_start(k);
        for (int i = 0; i < NV; i++) begin
            feed(k, i, 1'b0, acc);
            chk(acc, "R4", {req, " entry accepted"}, int'(acc), 1);
        end
        wait_end(k, 400, d, e, r, cyc);
        chk(d && !e, "R9", {req, " done pulse without error"}, int'(d), 1);
        @(negedge clk);
        chk(!done_s[k] && !ready_s[k], "R9", {req, " done lasts one cycle, then idle"},
            int'(done_s[k]), 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit acc, d, e, r;
        int cyc, ec0, wc0;
        for (int k = 0; k < 2; k++) begin
            start_s[k] = 0; valid_s[k] = 0; iaddr_s[k] = 0; idata_s[k] = 0;
            ilast_s[k] = 0; wrt_s[k] = 8; mfr_s[k] = 8'h1E; corr_s[k] = 0; peek_a[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 2; k++) begin
            chk(pstb_s[k] && !phv_s[k] && psel_s[k] == 2'b11 && pmode_s[k] == 3'd0,
                "R1", "port idle in reset", int'(pmode_s[k]), 0);
            chk(!ready_s[k] && !done_s[k] && !err_s[k], "R1", "flags low in reset",
                int'(ready_s[k]), 0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Main table walk, ready/busy completion
        run_full(0, "rb");
        chk(erase_c[0] == 1, "R3", "one erase per run", erase_c[0], 1);
        chk(er_l[0] == ERASE_CYC, "R3", "erase strobe length", er_l[0], ERASE_CYC);
        chk(pu_l[0] == PULSE_CYC, "R4", "write pulse length", pu_l[0], PULSE_CYC);
        chk(su_l[0] == SETUP_CYC, "R4", "setup before pulse", su_l[0], SETUP_CYC);
        chk(bad_c[0] == 0, "R4", "strobe with hv and after erase", bad_c[0], 0);
        chk(write_c[0] == NV, "R4", "one write per entry", write_c[0], NV);
        chk(poll_c[0] == 0, "R5", "no array read while busy", poll_c[0], 0);
        for (int i = 0; i < NV; i++) begin
            peek_a[0] = VEC[i][15:8];
            #1;
            chk(peek_d[0] == VEC[i][7:0], "R7", "image byte in array",
                int'(peek_d[0]), int'(VEC[i][7:0]));
        end
        chk(pstb_s[0] && !phv_s[0] && pmode_s[0] == 3'd0, "R1", "idle after done",
            int'(pmode_s[0]), 0);

        // Polling completion, with a quiet fetch phase first
        pulse_start(1);
        for (int c = 0; c < 100 && !ready_s[1]; c++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(ready_s[1] && pstb_s[1] && !phv_s[1], "R11", "fetch leaves port quiet",
            int'(phv_s[1]), 0);
        for (int i = 0; i < NV; i++) begin
            feed(1, i, 1'b0, acc);
            chk(acc, "R6", "poll entry accepted", int'(acc), 1);
        end
        wait_end(1, 400, d, e, r, cyc);
        chk(d && !e, "R6", "poll run completes", int'(d), 1);
        chk(poll_c[1] > 0, "R6", "status polled during write", poll_c[1], 1);
        chk(write_c[1] == NV, "R6", "poll writes", write_c[1], NV);
        for (int i = 0; i < NV; i++) begin
            peek_a[1] = VEC[i][15:8];
            #1;
            chk(peek_d[1] == VEC[i][7:0], "R6", "poll image byte",
                int'(peek_d[1]), int'(VEC[i][7:0]));
        end

        // Wrong signature
        ec0 = erase_c[0];
        mfr_s[0] = 8'h55;
        pulse_start(0);
        wait_end(0, 100, d, e, r, cyc);
        chk(e && !d, "R2", "bad signature sets error", int'(e), 1);
        chk(erase_c[0] == ec0, "R2", "no erase after bad signature", erase_c[0], ec0);
        chk(!r, "R2", "no entry offered after bad signature", int'(r), 0);
        repeat (20) @(negedge clk);
        chk(err_s[0], "R10", "error held until start", int'(err_s[0]), 1);

        // Restart clears the error
        mfr_s[0] = 8'h1E;
        pulse_start(0);
        chk(!err_s[0], "R10", "start clears error", int'(err_s[0]), 0);
        for (int i = 0; i < NV; i++) feed(0, i, 1'b0, acc);
        wait_end(0, 400, d, e, r, cyc);
        chk(d && !e, "R10", "run after restart completes", int'(d), 1);
        chk(erase_c[0] == ec0 + 1, "R3", "restart erases again", erase_c[0], ec0 + 1);

        // Read-back mismatch while the next entry waits
        corr_s[0] = 1'b1;
        wc0 = write_c[0];
        pulse_start(0);
        feed(0, 0, 1'b0, acc);
        wait_end(0, 200, d, e, r, cyc);
        chk(e && !d, "R7", "mismatch sets error", int'(e), 1);
        feed(0, 1, 1'b1, acc);
        chk(!acc, "R7", "no entry taken after mismatch", int'(acc), 0);
        valid_s[0] = 1'b0;
        chk(write_c[0] == wc0 + 1, "R7", "single write before stop", write_c[0], wc0 + 1);
        corr_s[0] = 1'b0;

        // Slow device: timeout against completion
        wrt_s[0] = 200;
        pulse_start(0);
        feed(0, 0, 1'b0, acc);
        wait_end(0, 200, d, e, r, cyc);
        chk(e && !d, "R8", "timeout sets error", int'(e), 1);
        chk(cyc >= TIMEOUT_CYC, "R8", "error not before timeout", cyc, TIMEOUT_CYC);
        repeat (220) @(negedge clk);
        wrt_s[0] = 8;

        // Slow device, polling variant
        wrt_s[1] = 200;
        pulse_start(1);
        feed(1, 2, 1'b0, acc);
        wait_end(1, 200, d, e, r, cyc);
        chk(e && !d, "R8", "poll timeout sets error", int'(e), 1);
        repeat (220) @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule